// File: doc/BRIEF.md
# Accumulator Multiply/Divide Unit

This unit performs unsigned byte multiplication and word-by-byte division for a small controller core. It works on two 16-bit registers: an accumulator (A) and a companion temporary register (T). The core presents the current A and T values, raises a start strobe, and selects the operation with a one-bit opcode. When the operation finishes, the unit returns the new A and T values together with a one-cycle completion pulse, and the core writes them back.

Multiplication reads only the low bytes of A and T and finishes one cycle after it is accepted. Division takes the whole of T as the dividend and the low byte of A as the divisor. It runs a restoring shift-subtract loop, one quotient bit per clock, for 16 clocks. The quotient goes to the low byte of A and the remainder to the low byte of T, and both upper bytes are cleared. The unit reports no overflow, no error for a zero divisor, and no flags.

The controller FSM has two states. `S_IDLE` waits for a strobe. Its transitions are: idle-to-idle on a multiply, which is written back directly, and idle-to-run on a divide, which loads the divider. `S_RUN` performs one division step per cycle. Its transitions are: run-to-run while the step counter is below its last value, and run-to-idle on the last step, which writes back the division result.

Top module: `acc_muldiv`

## Requirements
- R1: Multiply (op_div_i=0) writes the 16-bit unsigned product a_i[7:0]*t_i[7:0] to a_o and returns t_i unchanged on t_o.
- R2: The upper bytes a_i[15:8] and t_i[15:8] have no effect on the multiply product.
- R3: Divide (op_div_i=1) treats t_i[15:0] as the dividend and a_i[7:0] as the divisor, and ignores a_i[15:8]. When the true quotient fits in 8 bits, a_o[7:0] is the quotient and t_o[7:0] is the remainder.
- R4: After a divide, a_o[15:8] and t_o[15:8] are zero.
- R5: When the true quotient exceeds 8 bits, a_o[7:0] is its low 8 bits and t_o[7:0] is the true remainder. No indication is given.
- R6: A zero divisor gives a_o=16'h00FF and t_o={8'h00, t_i[7:0]}.
- R7: done_o is high in the cycle after the edge that accepts a multiply strobe. busy_o stays low throughout a multiply.
- R8: For a divide, busy_o is high from the accepting edge until done_o rises, which happens 16 edges after the accepting edge (17 edges counted from the accepting edge inclusive).
- R9: A start_i seen while busy_o is high produces no completion and does not alter the running divide.
- R10: Each accepted operation produces exactly one completion cycle. a_o and t_o hold their values between completions. A strobe in a completion cycle is accepted.
- R11: Reset drives busy_o and done_o low and a_o and t_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation strobe, sampled when idle |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| a_i | input | 16 | Current accumulator value |
| t_i | input | 16 | Current temporary register value |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | Completion pulse; a_o/t_o valid |
| a_o | output | 16 | New accumulator value |
| t_o | output | 16 | New temporary register value |

## Verification
The hardest case to reach from the ports is a strobe arriving in the middle of a divide, since it must be ignored without disturbing the captured divisor or the partial remainder. The driver raises start_i with different operands and the other opcode for several cycles right after a divide is accepted. The scoreboard then requires exactly one completion carrying the original operands' result. Random divides are built from a chosen quotient, divisor and remainder, so the quotient fits in 8 bits. Directed cases cover a zero divisor, a quotient wider than 8 bits and multiplies issued back to back in completion cycles.

// File: rtl/acc_muldiv_pkg.sv
package acc_muldiv_pkg;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/acc_muldiv_mul.sv
module acc_muldiv_mul #(
    parameter int DATA_W    = 8,
    parameter bit USE_ARRAY = 1'b1,
    localparam int PROD_W   = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    output logic [PROD_W-1:0] prod_o
);

    generate
        if (USE_ARRAY) begin : g_array
            // shift-and-add partial product array
            logic [PROD_W-1:0] pp [DATA_W];
            for (genvar i = 0; i < DATA_W; i++) begin : g_pp
                assign pp[i] = rhs_i[i] ? ({{DATA_W{1'b0}}, lhs_i} << i) : '0;
            end
            always_comb begin
                prod_o = '0;
                for (int k = 0; k < DATA_W; k++) begin
                    prod_o = prod_o + pp[k];
                end
            end
        end else begin : g_operator
            assign prod_o = PROD_W'(lhs_i) * PROD_W'(rhs_i);
        end
    endgenerate

endmodule

// File: rtl/acc_muldiv_div.sv
module acc_muldiv_div #(
    parameter int DATA_W  = 8,
    localparam int WIDE_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [WIDE_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    output logic [DATA_W-1:0] quot_nxt_o,
    output logic [DATA_W-1:0] rem_nxt_o
);

    logic [DATA_W-1:0] divisor_q;
    logic [DATA_W-1:0] rem_q;
    logic [WIDE_W-1:0] quo_q;

    logic [DATA_W:0]   shifted;
    logic [DATA_W:0]   diff;
    logic              fits;
    logic [DATA_W-1:0] rem_nxt;
    logic [WIDE_W-1:0] quo_nxt;

    // one restoring step: bring in next dividend bit, trial subtract
    always_comb begin
        shifted = {rem_q, quo_q[WIDE_W-1]};
        diff    = shifted - {1'b0, divisor_q};
        fits    = (shifted >= {1'b0, divisor_q});
        rem_nxt = fits ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
        quo_nxt = {quo_q[WIDE_W-2:0], fits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divisor_q <= '0;
            rem_q     <= '0;
            quo_q     <= '0;
        end else if (load_i) begin
            divisor_q <= divisor_i;
            rem_q     <= '0;
            quo_q     <= dividend_i;
        end else if (step_i) begin
            rem_q     <= rem_nxt;
            quo_q     <= quo_nxt;
        end
    end

    assign quot_nxt_o = quo_nxt[DATA_W-1:0];
    assign rem_nxt_o  = rem_nxt;

    // R9
    divisor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> $stable(divisor_q));

    // R5
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && divisor_q != '0) |-> (rem_q < divisor_q));

endmodule

// File: rtl/acc_muldiv_ctrl.sv
module acc_muldiv_ctrl
    import acc_muldiv_pkg::*;
#(
    parameter int STEPS  = 16,
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic op_div_i,
    output logic busy_o,
    output logic mul_wr_o,
    output logic div_load_o,
    output logic div_step_o,
    output logic div_last_o
);

    ctl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i && op_e'(op_div_i) == OP_DIV) state_d = S_RUN;
            S_RUN:  if (cnt_q == LAST) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (div_load_o) begin
            cnt_q <= '0;
        end else if (div_step_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        accept     = 1'b0;
        busy_o     = 1'b0;
        mul_wr_o   = 1'b0;
        div_load_o = 1'b0;
        div_step_o = 1'b0;
        div_last_o = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                accept     = start_i;
                mul_wr_o   = accept && op_e'(op_div_i) == OP_MUL;
                div_load_o = accept && op_e'(op_div_i) == OP_DIV;
            end
            S_RUN: begin
                busy_o     = 1'b1;
                div_step_o = 1'b1;
                div_last_o = (cnt_q == LAST);
            end
            default: ;
        endcase
    end

    // R8
    run_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_step_o && !div_last_o) |=> busy_o);

    // R8
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_last_o |=> !busy_o);

    // R8
    load_enters_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_load_o |=> (busy_o && cnt_q == '0));

    // R9
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || $past(div_last_o)));

endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv #(
    parameter int DATA_W    = 8,
    parameter bit MUL_ARRAY = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  op_div_i,
    input  logic [2*DATA_W-1:0]   a_i,
    input  logic [2*DATA_W-1:0]   t_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [2*DATA_W-1:0]   a_o,
    output logic [2*DATA_W-1:0]   t_o
);

    localparam int WIDE_W = 2 * DATA_W;
    localparam int STEPS  = WIDE_W;

    logic              mul_wr;
    logic              div_load;
    logic              div_step;
    logic              div_last;
    logic [WIDE_W-1:0] product;
    logic [DATA_W-1:0] quot_nxt;
    logic [DATA_W-1:0] rem_nxt;
    logic [WIDE_W-1:0] a_q, t_q;
    logic              done_q;
    logic              unused_a_hi;

    assign unused_a_hi = ^a_i[WIDE_W-1:DATA_W];

    acc_muldiv_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_div_i   (op_div_i),
        .busy_o     (busy_o),
        .mul_wr_o   (mul_wr),
        .div_load_o (div_load),
        .div_step_o (div_step),
        .div_last_o (div_last)
    );

    acc_muldiv_mul #(.DATA_W(DATA_W), .USE_ARRAY(MUL_ARRAY)) u_mul (
        .lhs_i  (a_i[DATA_W-1:0]),
        .rhs_i  (t_i[DATA_W-1:0]),
        .prod_o (product)
    );

    acc_muldiv_div #(.DATA_W(DATA_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (div_load),
        .step_i     (div_step),
        .dividend_i (t_i),
        .divisor_i  (a_i[DATA_W-1:0]),
        .quot_nxt_o (quot_nxt),
        .rem_nxt_o  (rem_nxt)
    );

    // register write-back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            t_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= mul_wr || div_last;
            if (mul_wr) begin
                a_q <= product;
                t_q <= t_i;
            end else if (div_last) begin
                a_q <= {{DATA_W{1'b0}}, quot_nxt};
                t_q <= {{DATA_W{1'b0}}, rem_nxt};
            end
        end
    end

    assign a_o    = a_q;
    assign t_o    = t_q;
    assign done_o = done_q;

    // R10
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mul_wr || div_last));

    // R4
    div_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(div_last)) |-> (a_o[WIDE_W-1:DATA_W] == '0 && t_o[WIDE_W-1:DATA_W] == '0));

    // R1
    mul_t_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(mul_wr)) |-> (t_o == $past(t_i)));

    // R7
    mul_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_wr |=> (done_o && !busy_o));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mul_wr || div_last) |=> ($stable(a_o) && $stable(t_o)));

endmodule

// File: tb/acc_muldiv_tb.sv
module acc_muldiv_tb;

    typedef struct {
        logic [15:0] ea;
        logic [15:0] et;
        int          due;
        int          kind;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_div_i = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] t_i = '0;
    logic        busy_o, done_o;
    logic [15:0] a_o, t_o;

    int   tests = 0;
    int   fails = 0;
    int   cyc = 0;
    exp_t sb[$];
    logic        hold_pend = 1'b0;
    logic [15:0] last_a = '0, last_t = '0;

    acc_muldiv u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_div_i(op_div_i),
        .a_i(a_i), .t_i(t_i), .busy_o(busy_o), .done_o(done_o),
        .a_o(a_o), .t_o(t_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic string req_of(input int kind);
        case (kind)
            0: return "R1";
            1: return "R3";
            2: return "R2";
            3: return "R5";
            4: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: issue one op starting at a negedge with the unit idle
    task automatic run_op(input bit div, input logic [15:0] a, input logic [15:0] t,
                          input int kind, input bit poke);
        exp_t e;
        logic [7:0]  d;
        logic [15:0] q, r;
        if (!div) begin
            e.ea = 16'(a[7:0]) * 16'(t[7:0]);
            e.et = t;
        end else begin
            d = a[7:0];
            if (d == 8'h00) begin
                e.ea = 16'h00FF;
                e.et = {8'h00, t[7:0]};
            end else begin
                q = t / 16'(d);
                r = t % 16'(d);
                e.ea = {8'h00, q[7:0]};
                e.et = {8'h00, r[7:0]};
            end
        end
        e.due  = cyc + (div ? 17 : 1);
        e.kind = kind;
        sb.push_back(e);
        start_i  = 1'b1;
        op_div_i = div;
        a_i      = a;
        t_i      = t;
        @(negedge clk);
        start_i = 1'b0;
        if (div) check(busy_o === 1'b1, "R8", "busy after divide accept", 32'(busy_o), 32'd1);
        else     check(busy_o === 1'b0, "R7", "busy during multiply", 32'(busy_o), 32'd0);
        if (div && poke) begin
            start_i  = 1'b1;
            op_div_i = $urandom_range(0, 1);
            a_i      = 16'($urandom);
            t_i      = 16'($urandom);
            repeat (3) @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && !done_o) begin
                check(a_o === last_a && t_o === last_t, "R10", "hold between completions",
                      {a_o, t_o}, {last_a, last_t});
            end
            hold_pend <= 1'b0;
            if (done_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "completion with nothing pending", 32'(a_o), 32'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(a_o === e.ea, req_of(e.kind), "A result", 32'(a_o), 32'(e.ea));
                    check(t_o === e.et, req_of(e.kind), "T result", 32'(t_o), 32'(e.et));
                    check(cyc == e.due, (e.kind == 0 || e.kind == 2) ? "R7" : "R8",
                          "completion cycle", 32'(cyc), 32'(e.due));
                    if (e.kind != 0 && e.kind != 2)
                        check(a_o[15:8] == 8'h00 && t_o[15:8] == 8'h00, "R4",
                              "upper bytes cleared", {a_o[15:8], t_o[15:8]}, 32'h0);
                    last_a    <= a_o;
                    last_t    <= t_o;
                    hold_pend <= 1'b1;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 32'(cyc), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy_o === 1'b0 && done_o === 1'b0, "R11", "busy/done in reset",
              {busy_o, done_o}, 32'h0);
        check(a_o === 16'h0 && t_o === 16'h0, "R11", "outputs in reset", {a_o, t_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0, "R11", "idle after reset",
              {busy_o, done_o}, 32'h0);

        // R1 / R3 worked examples
        run_op(1'b0, 16'h5678, 16'h1234, 0, 1'b0);
        run_op(1'b1, 16'h5678, 16'h1862, 1, 1'b0);
        // R1 extreme operands, back to back
        run_op(1'b0, 16'h00FF, 16'h00FF, 0, 1'b0);
        run_op(1'b0, 16'hAB00, 16'hCD00, 0, 1'b0);
        // R2 same low bytes, different upper bytes
        run_op(1'b0, 16'h1137, 16'h22C5, 2, 1'b0);
        run_op(1'b0, 16'hEE37, 16'h99C5, 2, 1'b0);
        // R3 largest fitting quotient, upper A byte set
        run_op(1'b1, 16'h77FF, 16'hFEFF, 1, 1'b0);
        // R5 quotient wider than 8 bits
        run_op(1'b1, 16'h0002, 16'h1234, 3, 1'b0);
        run_op(1'b1, 16'h0001, 16'hFFFF, 3, 1'b0);
        // R6 zero divisor
        run_op(1'b1, 16'hFF00, 16'hBEEF, 4, 1'b0);
        // R9 strobes during busy
        run_op(1'b1, 16'h3A11, 16'h0C35, 5, 1'b1);
        run_op(1'b1, 16'h0000, 16'h1357, 5, 1'b1);

        for (int i = 0; i < 40; i++) begin
            run_op(1'b0, 16'($urandom), 16'($urandom), 0, 1'b0);
        end
        for (int i = 0; i < 40; i++) begin
            logic [7:0]  dv, qt, rm;
            logic [15:0] dd;
            dv = 8'($urandom_range(1, 255));
            qt = 8'($urandom_range(0, 255));
            rm = 8'($urandom_range(0, int'(dv) - 1));
            dd = 16'(qt) * 16'(dv) + 16'(rm);
            run_op(1'b1, {8'($urandom), dv}, dd, (i % 4 == 0) ? 5 : 1, (i % 4 == 0));
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R10", "all operations completed", 32'(sb.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule